// File: doc/BRIEF.md
# Divider Dither Noise Canceller

This block sits between the time-to-digital converter and the loop filter of a digital fractional-N PLL. Each reference cycle it is handed three things: the fractional frequency word that drives the delta-sigma modulator, the signed offset that the modulator applied to the divide value, and the phase-error word from the TDC. From the first two it rebuilds the phase disturbance that the divider dithering introduces. That disturbance is the running sum of the modulator's quantization error.

It scales this prediction by a learned gain and subtracts it from the TDC word, entirely in digital arithmetic. The gain is learned in the background. A sign-data LMS correlator multiplies the sign of the prediction by the corrected residual, and the result is shifted right by a programmable step and accumulated. A first-order lowpass filter then smooths the accumulated value before it is applied. Adaptation and subtraction run only while `enable` is high, which the loop raises once the coarse path is frozen and the loop is locked. When `enable` is low the TDC word passes through untouched and the gain is held.

Top module: `dither_cancel`

## Requirements
- R1: After reset, `out_vld` is 0 and `tdc_out`, `gain_out` and `pred_out` are all 0.
- R2: On every cycle with `sample_vld` high, the prediction grows by the quantization error `div_off*2^FRAC_W - frac_in` (two's-complement `div_off`, unsigned `frac_in`, prediction in units of 2^-FRAC_W divider periods). The new prediction appears on `pred_out` one clock later, and `out_vld` is high for exactly that one cycle.
- R3: The prediction saturates at +2^(PRED_W-1)-1 and at -2^(PRED_W-1) instead of wrapping.
- R4: With `enable` low, `tdc_out` equals the sampled `tdc_in`, and `gain_out` keeps its value.
- R5: With `enable` low or high, the new prediction is the one used for correction. With `enable` high, `tdc_out` is `tdc_in - floor(gain*pred / 2^(GAIN_FRAC+FRAC_W))`, where `gain` is the value of `gain_out` before the sample. The result is saturated to the TDC word range.
- R6: With `enable` high, the gain integrator adds `sign(pred) * floor(tdc_out / 2^mu_sel)`, where sign is +1, 0 or -1. The integrator saturates to the GAIN_W signed range.
- R7: With `enable` high, `gain_out` moves by `floor((integrator_before - gain_out) / 2^LPF_SHIFT)`. The filter therefore follows the integrator value from before the sample.
- R8: When the TDC word equals a fixed multiple of the predicted phase, adaptation drives `gain_out` to that multiple (in Q.GAIN_FRAC units) and drives the corrected residual to within a few LSB of zero.
- R9: Cycles with `sample_vld` low change none of `tdc_out`, `gain_out` or `pred_out`, and `out_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | One reference-cycle sample is present |
| enable | input | 1 | Cancellation and adaptation on (locked state) |
| mu_sel | input | MU_W | Right shift of the LMS update step |
| frac_in | input | FRAC_W | Fractional word fed to the modulator |
| div_off | input | OFF_W | Signed divide offset chosen by the modulator |
| tdc_in | input | TDC_W | Signed TDC phase-error word |
| out_vld | output | 1 | Corrected word valid |
| tdc_out | output | TDC_W | Corrected phase-error word to the loop filter |
| gain_out | output | GAIN_W | Filtered scale factor currently applied |
| pred_out | output | PRED_W | Predicted dither phase error |

## Verification
The first pattern is a mix of offsets and fractions with cancellation off. It separates the prediction path from the correction path: the prediction must move while the word passes through and the gain stays put. The second pattern is a first-order dither stream, with the TDC word made proportional to the true accumulated phase. It shows whether the correlator pushes the gain in the right direction and settles near the known slope, and every intermediate value is checked against a reference model. A large-offset run drives the prediction into both rails, and then cancellation is enabled at the negative rail. This exposes wrapping in the accumulator and in the output subtraction. A run with a nonzero update shift and a TDC offset checks that the step is scaled as programmed.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int unsigned DC_FRAC_W    = 8;
    localparam int unsigned DC_OFF_W     = 4;
    localparam int unsigned DC_TDC_W     = 12;
    localparam int unsigned DC_PRED_W    = 16;
    localparam int unsigned DC_GAIN_W    = 16;
    localparam int unsigned DC_GAIN_FRAC = 8;
    localparam int unsigned DC_MU_W      = 3;
    localparam int unsigned DC_LPF_SHIFT = 2;

    typedef enum logic [1:0] {
        SGN_ZERO = 2'd0,
        SGN_POS  = 2'd1,
        SGN_NEG  = 2'd2
    } sgn_e;
endpackage

// File: rtl/dc_err_accum.sv
module dc_err_accum #(
    parameter int unsigned FRAC_W = dc_pkg::DC_FRAC_W,
    parameter int unsigned OFF_W  = dc_pkg::DC_OFF_W,
    parameter int unsigned PRED_W = dc_pkg::DC_PRED_W
) (
    input  logic        [FRAC_W-1:0] frac_in,
    input  logic signed [OFF_W-1:0]  div_off,
    input  logic signed [PRED_W-1:0] pred_q,
    output logic signed [PRED_W-1:0] pred_d
);
    localparam int unsigned ERR_W = OFF_W + FRAC_W + 1;
    localparam int unsigned SUM_W = PRED_W + 1;

    logic signed [ERR_W-1:0] qerr;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        qerr = $signed({div_off[OFF_W-1], div_off, {FRAC_W{1'b0}}})
             - $signed({{(OFF_W+1){1'b0}}, frac_in});
        sum  = SUM_W'(pred_q) + SUM_W'(qerr);
        if (sum[SUM_W-1] != sum[SUM_W-2]) begin
            pred_d = sum[SUM_W-1] ? {1'b1, {(PRED_W-1){1'b0}}}
                                  : {1'b0, {(PRED_W-1){1'b1}}};
        end else begin
            pred_d = sum[PRED_W-1:0];
        end
    end
endmodule

// File: rtl/dc_scaler.sv
module dc_scaler #(
    parameter int unsigned TDC_W  = dc_pkg::DC_TDC_W,
    parameter int unsigned PRED_W = dc_pkg::DC_PRED_W,
    parameter int unsigned GAIN_W = dc_pkg::DC_GAIN_W,
    parameter int unsigned SHIFT  = dc_pkg::DC_GAIN_FRAC + dc_pkg::DC_FRAC_W
) (
    input  logic                     enable,
    input  logic signed [TDC_W-1:0]  tdc_in,
    input  logic signed [PRED_W-1:0] pred,
    input  logic signed [GAIN_W-1:0] gain,
    output logic signed [TDC_W-1:0]  tdc_out
);
    localparam int unsigned PROD_W = PRED_W + GAIN_W;
    localparam int unsigned DIFF_W = PROD_W + 1;
    localparam logic signed [DIFF_W-1:0] TMAX =
        {{(DIFF_W-TDC_W+1){1'b0}}, {(TDC_W-1){1'b1}}};
    localparam logic signed [DIFF_W-1:0] TMIN =
        {{(DIFF_W-TDC_W+1){1'b1}}, {(TDC_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] corr;
    logic signed [DIFF_W-1:0] diff;

    always_comb begin
        prod = PROD_W'(gain) * PROD_W'(pred);
        corr = prod >>> SHIFT;
        diff = DIFF_W'(tdc_in) - DIFF_W'(corr);
        if (!enable) begin
            tdc_out = tdc_in;
        end else if (diff > TMAX) begin
            tdc_out = {1'b0, {(TDC_W-1){1'b1}}};
        end else if (diff < TMIN) begin
            tdc_out = {1'b1, {(TDC_W-1){1'b0}}};
        end else begin
            tdc_out = diff[TDC_W-1:0];
        end
    end
endmodule

// File: rtl/dc_gain_adapt.sv
module dc_gain_adapt #(
    parameter int unsigned TDC_W     = dc_pkg::DC_TDC_W,
    parameter int unsigned PRED_W    = dc_pkg::DC_PRED_W,
    parameter int unsigned GAIN_W    = dc_pkg::DC_GAIN_W,
    parameter int unsigned MU_W      = dc_pkg::DC_MU_W,
    parameter int unsigned LPF_SHIFT = dc_pkg::DC_LPF_SHIFT
) (
    input  logic                     enable,
    input  logic signed [PRED_W-1:0] pred,
    input  logic signed [TDC_W-1:0]  resid,
    input  logic        [MU_W-1:0]   mu_sel,
    input  logic signed [GAIN_W-1:0] acc_q,
    input  logic signed [GAIN_W-1:0] filt_q,
    output logic signed [GAIN_W-1:0] acc_d,
    output logic signed [GAIN_W-1:0] filt_d
);
    import dc_pkg::*;

    localparam int unsigned AW = GAIN_W + 1;

    sgn_e                    psgn;
    logic signed [TDC_W-1:0] step;
    logic signed [AW-1:0]    asum;
    logic signed [AW-1:0]    fdiff;
    logic signed [AW-1:0]    finc;
    logic signed [AW-1:0]    fsum;

    always_comb begin
        if (pred[PRED_W-1])  psgn = SGN_NEG;
        else if (|pred)      psgn = SGN_POS;
        else                 psgn = SGN_ZERO;

        step = resid >>> mu_sel;
        case (psgn)
            SGN_POS: asum = AW'(acc_q) + AW'(step);
            SGN_NEG: asum = AW'(acc_q) - AW'(step);
            default: asum = AW'(acc_q);
        endcase

        fdiff = AW'(acc_q) - AW'(filt_q);
        finc  = fdiff >>> LPF_SHIFT;
        fsum  = AW'(filt_q) + finc;

        acc_d  = acc_q;
        filt_d = filt_q;
        if (enable) begin
            if (asum[AW-1] != asum[AW-2]) begin
                acc_d = asum[AW-1] ? {1'b1, {(GAIN_W-1){1'b0}}}
                                   : {1'b0, {(GAIN_W-1){1'b1}}};
            end else begin
                acc_d = asum[GAIN_W-1:0];
            end
            if (fsum[AW-1] != fsum[AW-2]) begin
                filt_d = fsum[AW-1] ? {1'b1, {(GAIN_W-1){1'b0}}}
                                    : {1'b0, {(GAIN_W-1){1'b1}}};
            end else begin
                filt_d = fsum[GAIN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dither_cancel.sv
module dither_cancel #(
    parameter int unsigned FRAC_W    = dc_pkg::DC_FRAC_W,
    parameter int unsigned OFF_W     = dc_pkg::DC_OFF_W,
    parameter int unsigned TDC_W     = dc_pkg::DC_TDC_W,
    parameter int unsigned PRED_W    = dc_pkg::DC_PRED_W,
    parameter int unsigned GAIN_W    = dc_pkg::DC_GAIN_W,
    parameter int unsigned GAIN_FRAC = dc_pkg::DC_GAIN_FRAC,
    parameter int unsigned MU_W      = dc_pkg::DC_MU_W,
    parameter int unsigned LPF_SHIFT = dc_pkg::DC_LPF_SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_vld,
    input  logic                     enable,
    input  logic        [MU_W-1:0]   mu_sel,
    input  logic        [FRAC_W-1:0] frac_in,
    input  logic signed [OFF_W-1:0]  div_off,
    input  logic signed [TDC_W-1:0]  tdc_in,
    output logic                     out_vld,
    output logic signed [TDC_W-1:0]  tdc_out,
    output logic signed [GAIN_W-1:0] gain_out,
    output logic signed [PRED_W-1:0] pred_out
);
    localparam int unsigned SHIFT = GAIN_FRAC + FRAC_W;

    typedef struct packed {
        logic                     vld;
        logic signed [PRED_W-1:0] pred;
        logic signed [GAIN_W-1:0] acc;
        logic signed [GAIN_W-1:0] filt;
        logic signed [TDC_W-1:0]  tdc;
    } state_t;

    state_t st_q, st_d;

    logic signed [PRED_W-1:0] pred_nx;
    logic signed [TDC_W-1:0]  tdc_nx;
    logic signed [GAIN_W-1:0] acc_nx;
    logic signed [GAIN_W-1:0] filt_nx;

    dc_err_accum #(.FRAC_W(FRAC_W), .OFF_W(OFF_W), .PRED_W(PRED_W)) u_accum (
        .frac_in (frac_in),
        .div_off (div_off),
        .pred_q  (st_q.pred),
        .pred_d  (pred_nx)
    );

    dc_scaler #(.TDC_W(TDC_W), .PRED_W(PRED_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT)) u_scale (
        .enable  (enable),
        .tdc_in  (tdc_in),
        .pred    (pred_nx),
        .gain    (st_q.filt),
        .tdc_out (tdc_nx)
    );

    dc_gain_adapt #(
        .TDC_W(TDC_W), .PRED_W(PRED_W), .GAIN_W(GAIN_W),
        .MU_W(MU_W), .LPF_SHIFT(LPF_SHIFT)
    ) u_adapt (
        .enable (enable),
        .pred   (pred_nx),
        .resid  (tdc_nx),
        .mu_sel (mu_sel),
        .acc_q  (st_q.acc),
        .filt_q (st_q.filt),
        .acc_d  (acc_nx),
        .filt_d (filt_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = sample_vld;
        if (sample_vld) begin
            st_d.pred = pred_nx;
            st_d.tdc  = tdc_nx;
            st_d.acc  = acc_nx;
            st_d.filt = filt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign tdc_out  = st_q.tdc;
    assign gain_out = st_q.filt;
    assign pred_out = st_q.pred;
endmodule

module dither_cancel_chk #(
    parameter int unsigned TDC_W  = 12,
    parameter int unsigned GAIN_W = 16,
    parameter int unsigned PRED_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample_vld,
    input logic                     enable,
    input logic signed [TDC_W-1:0]  tdc_in,
    input logic                     out_vld,
    input logic signed [TDC_W-1:0]  tdc_out,
    input logic signed [GAIN_W-1:0] gain_out,
    input logic signed [PRED_W-1:0] pred_out
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> out_vld);
    // R9
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> !out_vld);
    // R4
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !enable) |=> (tdc_out == $past(tdc_in)));
    // R4
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !enable) |=> $stable(gain_out));
    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(pred_out) && $stable(gain_out) && $stable(tdc_out)));
endmodule

bind dither_cancel dither_cancel_chk #(.TDC_W(TDC_W), .GAIN_W(GAIN_W), .PRED_W(PRED_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .enable     (enable),
    .tdc_in     (tdc_in),
    .out_vld    (out_vld),
    .tdc_out    (tdc_out),
    .gain_out   (gain_out),
    .pred_out   (pred_out)
);

// File: tb/dither_cancel_test.sv
module dither_cancel_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_vld = 1'b0;
    logic              enable = 1'b0;
    logic [2:0]        mu_sel = '0;
    logic [7:0]        frac_in = '0;
    logic signed [3:0] div_off = '0;
    logic signed [11:0] tdc_in = '0;
    logic              out_vld;
    logic signed [11:0] tdc_out;
    logic signed [15:0] gain_out;
    logic signed [15:0] pred_out;

    dither_cancel uut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .enable(enable),
        .mu_sel(mu_sel), .frac_in(frac_in), .div_off(div_off), .tdc_in(tdc_in),
        .out_vld(out_vld), .tdc_out(tdc_out), .gain_out(gain_out), .pred_out(pred_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        longint tdc;
        longint gain;
        longint pred;
        string  req;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0;
    int     n_fail = 0;
    longint m_pred = 0, m_acc = 0, m_filt = 0;
    longint last_res = 0;
    bit     done = 1'b0;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clamp(longint v, int w);
        longint hi = (64'sd1 <<< (w - 1)) - 1;
        longint lo = -(64'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // driver: apply one sample and push the model's expectation
    task automatic send(longint off, longint frac, longint tdc, bit en, int mu, string req);
        exp_t   e;
        longint p, o, s, a, f;
        @(negedge clk);
        sample_vld = 1'b1;
        enable     = en;
        mu_sel     = mu[2:0];
        div_off    = off[3:0];
        frac_in    = frac[7:0];
        tdc_in     = tdc[11:0];
        p = clamp(m_pred + off * 256 - frac, 16);
        o = tdc;
        if (en) begin
            o = clamp(tdc - ((m_filt * p) >>> 16), 12);
            s = (p > 0) ? 1 : ((p < 0) ? -1 : 0);
            a = clamp(m_acc + s * (o >>> mu), 16);
            f = m_filt + ((m_acc - m_filt) >>> 2);
            m_acc  = a;
            m_filt = f;
        end
        m_pred = p;
        e.tdc = o; e.gain = m_filt; e.pred = m_pred; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_vld = 1'b0;
        end
    endtask

    // monitor: compare each produced result with the queued expectation
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 out_vld without sample", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(tdc_out == e.tdc,   {e.req, " tdc_out"},  tdc_out,  e.tdc);
                chk(gain_out == e.gain, {e.req, " gain_out"}, gain_out, e.gain);
                chk(pred_out == e.pred, {e.req, " pred_out"}, pred_out, e.pred);
                last_res = tdc_out;
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        longint facc, hold_gain, np, tdcv, off;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
        chk(tdc_out == 0,  "R1 tdc_out",  tdc_out, 0);
        chk(gain_out == 0, "R1 gain_out", gain_out, 0);
        chk(pred_out == 0, "R1 pred_out", pred_out, 0);
        rst_n = 1'b1;
        idle(2);

        // R2 R4: disabled, mixed offsets and fractions
        send(1, 77, 100, 0, 0, "R2/R4 dis");
        send(0, 200, -300, 0, 0, "R2/R4 dis");
        send(-1, 13, 2047, 0, 0, "R2/R4 dis");
        send(1, 255, -2048, 0, 0, "R2/R4 dis");
        send(0, 0, 5, 0, 0, "R2/R4 dis");
        idle(1);
        send(2, 128, 7, 0, 0, "R2/R4 dis");
        send(-2, 64, -7, 0, 0, "R2/R4 dis");
        idle(4);
        // R9 idle cycles change nothing
        chk(out_vld == 1'b0,   "R9 out_vld idle", out_vld, 0);
        chk(pred_out == m_pred, "R9 pred held", pred_out, m_pred);
        chk(gain_out == 0,      "R9 gain held", gain_out, 0);

        // R5 R6 R7 R8: adapt on a first-order dither stream, true slope 50 LSB/period
        facc = 0;
        for (int i = 0; i < 4000; i++) begin
            facc = facc + 77;
            off  = (facc >= 256) ? 1 : 0;
            facc = facc & 255;
            np   = clamp(m_pred + off * 256 - 77, 16);
            tdcv = clamp((50 * np) >>> 8, 12);
            send(off, 77, tdcv, 1, 0, "R5/R6/R7 adapt");
        end
        idle(3);
        // R8 convergence to 50*256
        chk((gain_out > 11520) && (gain_out < 14080), "R8 gain converged", gain_out, 12800);
        chk((last_res <= 4) && (last_res >= -4), "R8 residual small", last_res, 0);

        // R4 disabled after lock: gain holds, pass-through
        hold_gain = m_filt;
        send(1, 77, 333, 0, 0, "R4 hold");
        send(0, 77, -333, 0, 0, "R4 hold");
        idle(2);
        chk(gain_out == hold_gain, "R4 gain held", gain_out, hold_gain);
        chk(tdc_out == -333, "R4 passthrough", tdc_out, -333);

        // R6 coarser step with offset on the TDC word
        send(1, 77, 300, 1, 3, "R6 mu3");
        send(0, 77, 280, 1, 3, "R6 mu3");
        send(0, 77, -250, 1, 5, "R6 mu5");
        send(1, 40, 120, 1, 7, "R6 mu7");
        idle(2);

        // R3 prediction saturation at both rails
        for (int i = 0; i < 24; i++) send(7, 0, 0, 0, 0, "R3 pos");
        idle(2);
        chk(pred_out == 32767, "R3 positive rail", pred_out, 32767);
        for (int i = 0; i < 40; i++) send(-8, 0, 0, 0, 0, "R3 neg");
        idle(2);
        chk(pred_out == -32768, "R3 negative rail", pred_out, -32768);

        // R5 output saturation at the negative prediction rail
        send(-8, 0, -2000, 1, 0, "R5 sat");
        idle(2);
        chk(tdc_out == 2047, "R5 output saturates", tdc_out, 2047);

        idle(3);
        chk(sb.size() == 0, "R2 all results produced", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule